// File: doc/BRIEF.md
# Multiplexer-Tree Thermometer-to-Binary Decoder

This block converts the thermometer word produced by a flash converter's bank of comparators into an N-bit binary count. Bit k of the input (levels numbered from 1) is 1 once the sampled signal has reached level k. The input is therefore a run of ones that starts at the lowest tap, and the binary result is the length of that run.

The decoder works by halving the scale again and again instead of counting ones. The tap in the middle of the full scale gives the most significant bit. That bit then drives a column of 2:1 multiplexers, which passes on the upper half of the scale when the bit is 1 and the lower half when it is 0. The middle tap of the passed half gives the next bit. This repeats until a single multiplexer is left, and its output is the least significant bit. The structure uses sum over i=1..N-1 of (2^(N-i) − 1) multiplexers, which is 11 for N = 4, and its longest path is N − 1 multiplexer delays.

The resolution is a parameter. A second parameter chooses a combinational output or an output registered on the rising clock edge with a synchronous active-high reset. Bubble correction is not part of this block, so the input must be a clean thermometer code.

Top module: `therm2bin_mux_tree`

## Requirements
- R1: For every valid thermometer input (the lowest k bits set, 0 ≤ k ≤ 2^N − 1), the output equals k.
- R2: An all-zero input gives output 0.
- R3: An all-ones input (2^N − 1 bits) gives output 2^N − 1.
- R4: The output MSB equals input bit index 2^(N−1) − 1, which is level 2^(N−1) (level 8 for N = 4).
- R5: The decoder is correct for N = 5 (31 input bits) over all 32 valid codes, so the tree structure follows the parameter.
- R6: In registered mode the output takes the decoded value at the rising edge after the input is applied, and it holds until the next rising edge.
- R7: In registered mode, a rising edge with rst high clears the output to 0 whatever the input is.
- R8: In combinational mode the output follows a change of input without any clock edge.
- R9: Output bit N−2 equals the input at level 3·2^(N−2) when the MSB is 1, and the input at level 2^(N−2) when the MSB is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| therm_i | input | 2^N_BITS − 1 | Thermometer code; bit index k−1 is level k |
| bin_o | output | N_BITS | Binary count of the ones in therm_i |

## Verification
The properties assume that the input is monotonic: a run of ones anchored at bit 0 with nothing set above it. They test this by checking that the word ANDed with itself plus one is zero, and they check nothing in a cycle where it fails. The stimulus builds every input as exactly such a run, for each length from zero to full scale. No cycle is therefore left out of checking, and the bubbled codes the decoder does not handle are never applied.

// File: rtl/tdec_pkg.sv
package tdec_pkg;

    typedef enum logic {
        OUT_COMB = 1'b0,
        OUT_REG  = 1'b1
    } out_mode_e;

    function automatic int scale_w(input int nbits);
        return (2 ** nbits) - 1;
    endfunction

    function automatic int half_w(input int in_w);
        return (in_w - 1) / 2;
    endfunction

    function automatic int mux_count(input int nbits);
        int acc;
        acc = 0;
        for (int i = 1; i < nbits; i++) begin
            acc += (2 ** (nbits - i)) - 1;
        end
        return acc;
    endfunction

endpackage

// File: rtl/tdec_mux2.sv
module tdec_mux2 (
    input  logic sel_i,
    input  logic lo_i,
    input  logic hi_i,
    output logic y_o
);
    assign y_o = sel_i ? hi_i : lo_i;
endmodule

// File: rtl/tdec_mux_col.sv
module tdec_mux_col
    import tdec_pkg::*;
#(
    parameter int IN_W = 15
) (
    input  logic [IN_W-1:0]          scale_i,
    output logic                     pick_o,
    output logic [half_w(IN_W)-1:0]  half_o
);
    localparam int HW = half_w(IN_W);

    // the middle tap decides which half survives
    assign pick_o = scale_i[HW];

    for (genvar g = 0; g < HW; g++) begin : g_mux
        tdec_mux2 u_mux (
            .sel_i (pick_o),
            .lo_i  (scale_i[g]),
            .hi_i  (scale_i[HW + 1 + g]),
            .y_o   (half_o[g])
        );
    end
endmodule

// File: rtl/tdec_mux_tree.sv
module tdec_mux_tree
    import tdec_pkg::*;
#(
    parameter int N_BITS = 4
) (
    input  logic [scale_w(N_BITS)-1:0] therm_i,
    output logic [N_BITS-1:0]          raw_o
);
    localparam int COLS = N_BITS - 1;

    for (genvar j = 0; j < COLS; j++) begin : g_col
        localparam int IN_W  = scale_w(N_BITS - j);
        localparam int OUT_W = half_w(IN_W);

        logic [IN_W-1:0]  src;
        logic [OUT_W-1:0] dst;
        logic             pick;

        if (j == 0) begin : g_first
            assign src = therm_i;
        end else begin : g_next
            assign src = g_col[j-1].dst;
        end

        tdec_mux_col #(.IN_W(IN_W)) u_col (
            .scale_i (src),
            .pick_o  (pick),
            .half_o  (dst)
        );

        assign raw_o[N_BITS-1-j] = pick;
    end

    // the last column leaves a one-bit scale: that is the LSB
    assign raw_o[0] = g_col[COLS-1].dst[0];
endmodule

// File: rtl/tdec_out_stage.sv
module tdec_out_stage
    import tdec_pkg::*;
#(
    parameter int        W    = 4,
    parameter out_mode_e MODE = OUT_REG
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    if (MODE == OUT_REG) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) q_o <= '0;
            else     q_o <= d_i;
        end
    end else begin : g_comb
        assign q_o = d_i;
    end
endmodule

// File: rtl/therm2bin_mux_tree.sv
module therm2bin_mux_tree
    import tdec_pkg::*;
#(
    parameter int        N_BITS = 4,
    parameter out_mode_e MODE   = OUT_REG
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [scale_w(N_BITS)-1:0] therm_i,
    output logic [N_BITS-1:0]          bin_o
);
    logic [N_BITS-1:0] raw_bin;

    tdec_mux_tree #(.N_BITS(N_BITS)) u_tree (
        .therm_i (therm_i),
        .raw_o   (raw_bin)
    );

    tdec_out_stage #(.W(N_BITS), .MODE(MODE)) u_out (
        .clk (clk),
        .rst (rst),
        .d_i (raw_bin),
        .q_o (bin_o)
    );
endmodule

// File: rtl/tdec_checker.sv
module tdec_checker
    import tdec_pkg::*;
#(
    parameter int        N_BITS = 4,
    parameter out_mode_e MODE   = OUT_REG
) (
    input logic                       clk,
    input logic                       rst,
    input logic [scale_w(N_BITS)-1:0] therm_i,
    input logic [N_BITS-1:0]          bin_o
);
    localparam int MID = 2 ** (N_BITS - 1);
    localparam int QTR = 2 ** (N_BITS - 2);

    logic              valid_w;
    logic [N_BITS-1:0] ones_w;
    logic              second_w;
    logic              full_w;

    assign valid_w  = ((therm_i & (therm_i + 1'b1)) == '0);
    assign ones_w   = N_BITS'($countones(therm_i));
    assign second_w = therm_i[MID-1] ? therm_i[3*QTR-1] : therm_i[QTR-1];
    assign full_w   = &therm_i;

    if (MODE == OUT_REG) begin : g_reg_chk
        a_r1_count: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(valid_w)) |-> bin_o == $past(ones_w));
        a_r4_msb_tap: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(valid_w)) |-> bin_o[N_BITS-1] == $past(therm_i[MID-1]));
        a_r9_second_bit: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(valid_w)) |-> bin_o[N_BITS-2] == $past(second_w));
        a_r3_full_scale: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(full_w)) |-> (&bin_o));
        a_r7_reset_clear: assert property (@(posedge clk) disable iff (rst)
            $fell(rst) |-> bin_o == '0);
    end else begin : g_comb_chk
        a_r8_count: assert property (@(posedge clk) disable iff (rst)
            valid_w |-> bin_o == ones_w);
        a_r4_msb_tap: assert property (@(posedge clk) disable iff (rst)
            valid_w |-> bin_o[N_BITS-1] == therm_i[MID-1]);
        a_r9_second_bit: assert property (@(posedge clk) disable iff (rst)
            valid_w |-> bin_o[N_BITS-2] == second_w);
        a_r3_full_scale: assert property (@(posedge clk) disable iff (rst)
            full_w |-> (&bin_o));
    end
endmodule

bind therm2bin_mux_tree tdec_checker #(.N_BITS(N_BITS), .MODE(MODE)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .therm_i (therm_i),
    .bin_o   (bin_o)
);

// File: tb/therm2bin_mux_tree_bench.sv
module therm2bin_mux_tree_bench;
    import tdec_pkg::*;

    typedef struct {
        int    exp;
        string tag;
    } sb_item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [14:0] therm4 = '0;
    logic [30:0] therm5 = '0;
    logic [3:0]  bin4;
    logic [4:0]  bin5;

    int       checks = 0;
    int       fails  = 0;
    int       prev4  = 0;
    bit       done   = 1'b0;
    sb_item_t sb_q[$];

    always #10 clk = ~clk;

    therm2bin_mux_tree #(.N_BITS(4), .MODE(OUT_REG)) u_therm2bin_mux_tree (
        .clk (clk), .rst (rst), .therm_i (therm4), .bin_o (bin4)
    );

    therm2bin_mux_tree #(.N_BITS(5), .MODE(OUT_COMB)) u_therm2bin_mux_tree_n5 (
        .clk (clk), .rst (rst), .therm_i (therm5), .bin_o (bin5)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [14:0] code4(input int k);
        logic [14:0] t;
        for (int i = 0; i < 15; i++) t[i] = (i < k);
        return t;
    endfunction

    function automatic logic [30:0] code5(input int k);
        logic [30:0] t;
        for (int i = 0; i < 31; i++) t[i] = (i < k);
        return t;
    endfunction

    // driver for the registered instance: apply, check hold, push expectation
    task automatic drive4(input int k, input string tag, input bit do_rst);
        @(negedge clk);
        rst    = do_rst;
        therm4 = code4(k);
        #2;
        chk("R6 hold", int'(bin4), prev4);
        prev4 = do_rst ? 0 : k;
        sb_q.push_back('{exp: prev4, tag: tag});
    endtask

    // monitor: one result per rising edge
    always @(posedge clk) begin
        #2;
        if (sb_q.size() > 0) begin
            sb_item_t it;
            it = sb_q.pop_front();
            chk(it.tag, int'(bin4), it.exp);
        end
    end

    initial begin
        // reset with full-scale input: R7
        therm4 = '1;
        repeat (3) @(negedge clk);
        chk("R7 reset", int'(bin4), 0);

        // ascending sweep, registered N=4: R1, R2, R3
        for (int k = 0; k <= 15; k++) begin
            drive4(k, (k == 0) ? "R2" : ((k == 15) ? "R3" : "R1"), 1'b0);
        end
        // descending sweep
        for (int k = 15; k >= 0; k--) begin
            drive4(k, "R1 desc", 1'b0);
        end
        // MSB boundary around level 8: R4
        drive4(7, "R4", 1'b0);
        drive4(8, "R4", 1'b0);
        drive4(7, "R4", 1'b0);
        // second-bit selection in both halves: R9
        drive4(3, "R9", 1'b0);
        drive4(4, "R9", 1'b0);
        drive4(11, "R9", 1'b0);
        drive4(12, "R9", 1'b0);
        // reset in mid-stream: R7
        drive4(9, "R6", 1'b0);
        drive4(13, "R7", 1'b1);
        drive4(13, "R6", 1'b0);
        drive4(0, "R2", 1'b0);
        repeat (3) @(negedge clk);
        chk("R2 idle", int'(bin4), 0);

        // combinational N=5, every code: R5
        for (int k = 0; k <= 31; k++) begin
            @(negedge clk);
            therm5 = code5(k);
            #1;
            chk((k == 31) ? "R5 R3" : "R5", int'(bin5), k);
        end
        // changes with no edge in between: R8
        @(negedge clk);
        therm5 = code5(17);
        #1 chk("R8", int'(bin5), 17);
        therm5 = code5(3);
        #1 chk("R8", int'(bin5), 3);
        therm5 = code5(16);
        #1 chk("R8 R4", int'(bin5[4]), 1);

        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule